// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting channel of a classic interval timer. A processor programs it through a byte-wide synchronous write port: a control word picks the counting mode and how the count is transferred (low byte only, high byte only, or low byte followed by high byte), and then one or two data writes supply the count. A byte-wide read port returns the live count in the same byte order. Counting is paced by a separate count clock level, which the block samples in its own clock domain. Each falling edge of that count clock is one count step.

Three modes are supported. In terminal-count mode the output drops when the mode is set and rises once the count reaches zero. In rate mode the output pulses low for one count step each time the count reaches one, and the counter reloads on its own. In strobe mode the output pulses low for one count step when the count reaches zero, and only once per loaded count. Setting the mode always halts the counter. A new count only reaches the counting element at a count-clock falling edge that follows a rising edge seen after the last count byte was written.

Top module: `pit_channel`

## Requirements
- R1: After reset the mode is terminal count with two-byte transfer, the counter is halted and out_q is 0. Count-clock edges alone do not change out_q.
- R2: With wr_sel=1, a write is a control word only if bits 7:6 are 00, bit 0 is 0, bits 5:4 are not 00 and bits 3:1 are 000 (terminal count), 010 (rate) or 100 (strobe). Any other control write has no effect on mode, byte order, count or output.
- R3: An accepted control word halts the counter. The counter stays halted until a complete count has been written and loaded.
- R4: An accepted control word sets out_q, effective in the cycle after the write, to 0 for mode 000 and to 1 for modes 010 and 100.
- R5: Bits 5:4 of the control word pick the count transfer order: 01 writes the low byte only and clears the high byte, 10 writes the high byte only and clears the low byte, and 11 takes the low byte and then the high byte on two writes with wr_sel=0.
- R6: A completed count is moved into the counter only at a count-clock falling edge that follows a count-clock rising edge, both seen after the final byte was written. A falling edge without a prior rising edge does not load it.
- R7: In two-byte order, the first byte written halts an active count and the counter holds its value. The second byte starts the load of the new count.
- R8: Mode 000: out_q stays 0 after the load and goes to 1 at the falling edge that brings the count to 0. It then stays 1 while the counter keeps running with no reload.
- R9: Mode 010: out_q is 0 for exactly the count step in which the count equals 1. At the next falling edge the count reloads from the written value and out_q returns to 1, so the period is N steps.
- R10: Mode 100: out_q goes to 0 for one count step when the count reaches 0 and then back to 1. The counter wraps with no further strobe until a new count is loaded.
- R11: rd_data returns the count in the same order as the transfer setting: the low byte for 01, the high byte for 10, and alternately low then high on successive rd_en pulses for 11. The order restarts at the low byte after each accepted control word.
- R12: The counter changes only at a count-clock falling edge, and it decrements by one, wrapping from 0000h to FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 1 | 1 selects the control word, 0 selects the count bytes |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, advances the byte order for two-byte reads |
| rd_data | output | 8 | Current count byte |
| cnt_clk | input | 1 | Count clock level, sampled on clk |
| out_q | output | 1 | Timer output line |

## Verification
Each mode is run with counts chosen so the cycle where the output moves can be told apart from its neighbours. A count of 2 loaded while the count clock is already high shows whether a bare falling edge loads early. A count of 256 given as a high byte only shows whether the transfer order places the byte in the right half. A mid-count rewrite of the low byte shows whether the first byte halts the count and the second one starts the new count. A stream of malformed control words into a running rate count shows whether any of them leaks into the mode or byte order.

// File: rtl/pit_pkg.sv
package pit_pkg;

    parameter int BYTE_W = 8;
    parameter int CNT_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        MD_TERM = 3'b000,
        MD_RATE = 3'b010,
        MD_STRB = 3'b100
    } mode_e;

    typedef enum logic [1:0] {
        RL_NONE = 2'b00,
        RL_LO   = 2'b01,
        RL_HI   = 2'b10,
        RL_BOTH = 2'b11
    } rl_e;

    typedef struct packed {
        logic [1:0] sel;
        rl_e        rl;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_t;

    typedef struct packed {
        mode_e mode;
        rl_e   rl;
    } cfg_t;

    function automatic logic ctrl_ok(input ctrl_t c);
        logic mode_ok;
        mode_ok = (c.mode == 3'b000) || (c.mode == 3'b010) || (c.mode == 3'b100);
        return (c.sel == 2'b00) && (c.rl != RL_NONE) && !c.bcd && mode_ok;
    endfunction

    function automatic logic idle_level(input mode_e m);
        return m != MD_TERM;
    endfunction

endpackage

// File: rtl/pit_wr_seq.sv
module pit_wr_seq
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              mode_set,
    output mode_e             set_mode,
    output logic              cnt_done,
    output logic              cnt_hold,
    output logic [CNT_W-1:0]  cnt_reg
);
    ctrl_t cw;
    logic  hi_next;
    logic  cnt_wr;

    assign cw       = ctrl_t'(wr_data);
    assign mode_set = wr_en && wr_sel && ctrl_ok(cw);
    assign set_mode = mode_e'(cw.mode);
    assign cnt_wr   = wr_en && !wr_sel;
    assign cnt_hold = cnt_wr && (cfg.rl == RL_BOTH) && !hi_next;
    assign cnt_done = cnt_wr && ((cfg.rl == RL_LO) || (cfg.rl == RL_HI) ||
                                 ((cfg.rl == RL_BOTH) && hi_next));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{mode: MD_TERM, rl: RL_BOTH};
            cnt_reg <= '0;
            hi_next <= 1'b0;
        end else if (mode_set) begin
            cfg.mode <= set_mode;
            cfg.rl   <= cw.rl;
            hi_next  <= 1'b0;
        end else if (cnt_wr) begin
            case (cfg.rl)
                RL_LO: cnt_reg <= {{(CNT_W-BYTE_W){1'b0}}, wr_data};
                RL_HI: cnt_reg <= {wr_data, {(CNT_W-BYTE_W){1'b0}}};
                RL_BOTH: begin
                    if (!hi_next) cnt_reg[BYTE_W-1:0]     <= wr_data;
                    else          cnt_reg[CNT_W-1:BYTE_W] <= wr_data;
                    hi_next <= !hi_next;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pit_edge.sv
module pit_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign rise = lvl && !prev;
    assign fall = !lvl && prev;
endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             mode_set,
    input  mode_e            set_mode,
    input  logic             cnt_done,
    input  logic             cnt_hold,
    input  logic [CNT_W-1:0] cnt_reg,
    input  logic             rise,
    input  logic             fall,
    output logic [CNT_W-1:0] ce,
    output logic             run,
    output logic             pend,
    output logic             out_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic             saw_rise;
    logic             strobed;
    logic [CNT_W-1:0] ce_dec;

    assign ce_dec = ce - ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce       <= '0;
            run      <= 1'b0;
            pend     <= 1'b0;
            saw_rise <= 1'b0;
            strobed  <= 1'b0;
            out_q    <= 1'b0;
        end else if (mode_set) begin
            run      <= 1'b0;
            pend     <= 1'b0;
            saw_rise <= 1'b0;
            strobed  <= 1'b0;
            out_q    <= idle_level(set_mode);
        end else if (cnt_hold) begin
            run      <= 1'b0;
            pend     <= 1'b0;
            saw_rise <= 1'b0;
        end else if (cnt_done) begin
            pend     <= 1'b1;
            saw_rise <= 1'b0;
            if (mode == MD_TERM) out_q <= 1'b0;
        end else begin
            if (rise && pend) saw_rise <= 1'b1;
            if (fall) begin
                if (pend && saw_rise) begin
                    ce       <= cnt_reg;
                    run      <= 1'b1;
                    pend     <= 1'b0;
                    saw_rise <= 1'b0;
                    strobed  <= 1'b0;
                    out_q    <= idle_level(mode);
                end else if (run) begin
                    case (mode)
                        MD_RATE: begin
                            if (ce == ONE) begin
                                ce    <= cnt_reg;
                                out_q <= 1'b1;
                            end else begin
                                ce    <= ce_dec;
                                out_q <= (ce != TWO);
                            end
                        end
                        MD_STRB: begin
                            ce <= ce_dec;
                            if (ce == ONE && !strobed) begin
                                out_q   <= 1'b0;
                                strobed <= 1'b1;
                            end else begin
                                out_q <= 1'b1;
                            end
                        end
                        default: begin
                            ce <= ce_dec;
                            if (ce == ONE) out_q <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pit_rd.sv
module pit_rd
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              mode_set,
    input  rl_e               rl,
    input  logic [CNT_W-1:0]  ce,
    output logic [BYTE_W-1:0] rd_data
);
    logic hi_sel;

    always_ff @(posedge clk) begin
        if (rst || mode_set)              hi_sel <= 1'b0;
        else if (rd_en && rl == RL_BOTH)  hi_sel <= !hi_sel;
    end

    always_comb begin
        case (rl)
            RL_HI:   rd_data = ce[CNT_W-1:BYTE_W];
            RL_BOTH: rd_data = hi_sel ? ce[CNT_W-1:BYTE_W] : ce[BYTE_W-1:0];
            default: rd_data = ce[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        cnt_clk,
    output logic        out_q
);
    cfg_t             cfg_q;
    logic             mode_set;
    mode_e            set_mode;
    logic             cnt_done;
    logic             cnt_hold;
    logic [CNT_W-1:0] cnt_reg;
    logic             cnt_rise;
    logic             cnt_fall;
    logic [CNT_W-1:0] ce_q;
    logic             run_q;
    logic             pend_q;
    logic [2:0]       mode_bits;

    assign mode_bits = cfg_q.mode;

    pit_wr_seq u_wr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg(cfg_q), .mode_set(mode_set), .set_mode(set_mode),
        .cnt_done(cnt_done), .cnt_hold(cnt_hold), .cnt_reg(cnt_reg)
    );

    pit_edge u_edge (
        .clk(clk), .rst(rst), .lvl(cnt_clk), .rise(cnt_rise), .fall(cnt_fall)
    );

    pit_core u_core (
        .clk(clk), .rst(rst), .mode(cfg_q.mode), .mode_set(mode_set),
        .set_mode(set_mode), .cnt_done(cnt_done), .cnt_hold(cnt_hold),
        .cnt_reg(cnt_reg), .rise(cnt_rise), .fall(cnt_fall),
        .ce(ce_q), .run(run_q), .pend(pend_q), .out_q(out_q)
    );

    pit_rd u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .mode_set(mode_set),
        .rl(cfg_q.rl), .ce(ce_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [7:0]  wr_data,
    input logic        cnt_fall,
    input logic [15:0] ce,
    input logic        running,
    input logic        load_pend,
    input logic [2:0]  mode,
    input logic        out_q
);
    logic ctl_ok;
    assign ctl_ok = wr_en && wr_sel && (wr_data[7:6] == 2'b00) &&
                    (wr_data[5:4] != 2'b00) && !wr_data[0];

    assert_mode0_low_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_ok && wr_data[3:1] == 3'b000) |=> !out_q);

    assert_mode24_high_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_ok && (wr_data[3:1] == 3'b010 || wr_data[3:1] == 3'b100)) |=> out_q);

    assert_count_on_fall_R12: assert property (@(posedge clk) disable iff (rst)
        !cnt_fall |=> $stable(ce));

    assert_halted_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_pend) |=> $stable(ce));

    assert_out_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!cnt_fall && !wr_en) |=> $stable(out_q));

    assert_rate_low_at_one_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b010 && running && !out_q) |-> (ce == 16'd1));

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b100 && !out_q && cnt_fall && !wr_en) |=> out_q);
endmodule

bind pit_channel pit_channel_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_fall(cnt_fall), .ce(ce_q), .running(run_q), .load_pend(pend_q),
    .mode(mode_bits), .out_q(out_q)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       cnt_clk = 1'b0;
    logic       out_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pit_channel u_pit_channel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cnt_clk(cnt_clk), .out_q(out_q)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        cnt_clk = 1'b1;
        @(negedge clk);
        cnt_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk);
        b = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out after reset", out_q, 0);
        ticks(3);
        chk("R1 halted out", out_q, 0);
    endtask

    task automatic t_mode0();
        logic [7:0] b;
        wr(1, 8'h10);
        chk("R4 mode0 idle low", out_q, 0);
        wr(0, 8'h05);
        tick();
        rd(b);
        chk("R5 R11 loaded low byte", b, 8'h05);
        ticks(4);
        chk("R8 low before zero", out_q, 0);
        tick();
        chk("R8 high at zero", out_q, 1);
        tick();
        chk("R8 stays high", out_q, 1);
        rd(b);
        chk("R12 wrap to FFFF", b, 8'hFF);
    endtask

    task automatic t_late_rise();
        logic [7:0] b;
        wr(1, 8'h10);
        cnt_clk = 1'b1;
        @(negedge clk);
        wr(0, 8'h02);
        cnt_clk = 1'b0;
        @(negedge clk);
        tick();
        chk("R6 out after load", out_q, 0);
        tick();
        chk("R6 no early load", out_q, 0);
        rd(b);
        chk("R6 count one", b, 8'h01);
        tick();
        chk("R6 R8 zero reached", out_q, 1);
    endtask

    task automatic t_rate();
        logic [7:0] b;
        logic [7:0] h;
        wr(1, 8'h34);
        chk("R4 mode2 idle high", out_q, 1);
        wr(0, 8'h03);
        wr(0, 8'h00);
        tick();
        rd(b); rd(h);
        chk("R11 two-byte read low", b, 8'h03);
        chk("R11 two-byte read high", h, 8'h00);
        tick();
        chk("R9 high at two", out_q, 1);
        tick();
        chk("R9 low at one", out_q, 0);
        tick();
        chk("R9 reload high", out_q, 1);
        tick();
        tick();
        chk("R9 second pulse", out_q, 0);
    endtask

    task automatic t_ignored();
        logic [7:0] b;
        wr(1, 8'h14);
        wr(0, 8'h03);
        tick();
        wr(1, 8'h54);
        wr(1, 8'h04);
        wr(1, 8'h16);
        wr(1, 8'h15);
        tick();
        chk("R2 still counting", out_q, 1);
        tick();
        chk("R2 pulse kept", out_q, 0);
        tick();
        rd(b);
        chk("R2 order kept", b, 8'h03);
        chk("R2 reload high", out_q, 1);
    endtask

    task automatic t_ctrl_stop();
        int hi_cnt = 0;
        wr(1, 8'h14);
        wr(0, 8'h03);
        tick();
        tick();
        wr(1, 8'h14);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (out_q) hi_cnt++;
        end
        chk("R3 halted no pulse", hi_cnt, 6);
        wr(0, 8'h02);
        tick();
        tick();
        chk("R3 resumes after load", out_q, 0);
        wr(1, 8'h18);
        wr(0, 8'h09);
        tick();
        wr(1, 8'h10);
        chk("R4 mode0 forces low", out_q, 0);
        ticks(12);
        chk("R3 mode0 halted", out_q, 0);
    endtask

    task automatic t_rewrite();
        logic [7:0] b;
        logic [7:0] h;
        wr(1, 8'h30);
        wr(0, 8'h10);
        wr(0, 8'h00);
        tick();
        tick();
        wr(0, 8'h05);
        ticks(3);
        rd(b); rd(h);
        chk("R7 held low", b, 8'h0F);
        chk("R7 held high", h, 8'h00);
        wr(0, 8'h00);
        tick();
        rd(b); rd(h);
        chk("R7 new count low", b, 8'h05);
        chk("R7 new count high", h, 8'h00);
        ticks(4);
        chk("R7 R8 before zero", out_q, 0);
        tick();
        chk("R7 R8 at zero", out_q, 1);
    endtask

    task automatic t_msb();
        logic [7:0] b;
        wr(1, 8'h24);
        wr(0, 8'h01);
        tick();
        rd(b);
        chk("R5 high byte only", b, 8'h01);
        tick();
        rd(b);
        chk("R5 low byte cleared", b, 8'h00);
        ticks(253);
        chk("R9 long high", out_q, 1);
        tick();
        chk("R9 long low", out_q, 0);
        tick();
        rd(b);
        chk("R9 long reload", b, 8'h01);
        chk("R9 long back high", out_q, 1);
    endtask

    task automatic t_strobe();
        int hi_cnt = 0;
        wr(1, 8'h18);
        chk("R4 mode4 idle high", out_q, 1);
        wr(0, 8'h02);
        tick();
        chk("R10 high after load", out_q, 1);
        tick();
        chk("R10 high at one", out_q, 1);
        tick();
        chk("R10 strobe low", out_q, 0);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (out_q) hi_cnt++;
        end
        chk("R10 single strobe", hi_cnt, 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode0();
        t_late_rise();
        t_rate();
        t_ignored();
        t_ctrl_stop();
        t_rewrite();
        t_msb();
        t_strobe();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule